// File: doc/BRIEF.md
# Write-Only Serial Bus Receiver for a Volume Attenuator

This block is the bus front end of a two-channel volume attenuator. It watches a two-wire serial bus (SCL, SDA) with a system clock at least twenty times faster than SCL. Both lines pass through a synchronizer, and the block finds START and STOP conditions on the synchronized lines. It shifts in 8-bit bytes MSB first. The first byte after a START must equal the device address (0x88). When it does, the block acknowledges it. It then acknowledges every following byte and hands each one to a separate command decoder through a single-cycle strobe. The block only accepts writes: there is no read path, no clock stretching, no general call and no 10-bit addressing.

The controller is a state machine with six states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: holding the address acknowledge.
- `ST_DATA`: shifting in a data byte.
- `ST_DATA_ACK`: holding the data acknowledge.
- `ST_IGNORE`: the address did not match, so the bus is disregarded.

Two transitions apply from any state: a STOP goes to `ST_IDLE`, and a START goes to `ST_ADDR` with the bit count cleared. The other transitions all happen on an SCL falling edge:
- In `ST_ADDR`, after the eighth bit, a match goes to `ST_ADDR_ACK` and a mismatch goes to `ST_IGNORE`.
- `ST_ADDR_ACK` goes to `ST_DATA`.
- In `ST_DATA`, after the eighth bit, the block goes to `ST_DATA_ACK` and strobes the byte out.
- `ST_DATA_ACK` goes back to `ST_DATA`.

The SDA output is an active-low open-drain enable. A value of 0 means the block pulls the line low.

Top module: `vol_i2c_rx`

## Requirements
- R1: After reset, `sda_pull_n` is 1 (line released) and `rx_valid` is 0.
- R2: A START (SDA falling while SCL is high) begins address matching. An address byte equal to 0x88, received MSB first, is acknowledged: SDA is held low for the whole high phase of the ninth SCL clock.
- R3: An address byte other than 0x88 is not acknowledged. After it, the block neither acknowledges nor strobes any byte until the next START or STOP, even when a later byte equals 0x88.
- R4: Each data byte after a matched address is delivered MSB first on `rx_data`, with `rx_valid` high for exactly one system clock.
- R5: Every data byte in a matched transfer is acknowledged, and any number of data bytes may follow the address.
- R6: The block releases SDA (`sda_pull_n` returns to 1) on the SCL falling edge that ends each acknowledge clock, before the next bit's SCL rise.
- R7: A STOP (SDA rising while SCL is high) ends the transfer. Clock pulses that follow without a new START are neither acknowledged nor delivered.
- R8: A START in the middle of a transfer (repeated START) drops any partly received byte and restarts address matching. The dropped bits are never strobed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull_n | output | 1 | Open-drain enable, 0 = pull SDA low |
| rx_valid | output | 1 | One-cycle strobe for a received data byte |
| rx_data | output | 8 | Received data byte, valid with `rx_valid` |

## Verification
The bench builds the block with its defaults: address 0x88, a two-stage synchronizer and 8-bit bytes. It runs SCL at one fortieth of the system clock, so the synchronizer latency of a few cycles always lands well inside each SCL quarter period. That margin lets the bench check that the acknowledge covers the whole ninth high phase and that SDA is released before the next bit. The address table includes values that differ from 0x88 only in the LSB or only in the MSB, to show that every address bit is compared.

// File: rtl/vol_i2c_pkg.sv
package vol_i2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } rx_state_t;
endpackage

// File: rtl/vol_i2c_sync.sv
module vol_i2c_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= '1;
                end else if (g == 0) begin
                    chain[g] <= async_in;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/vol_i2c_cond.sv
module vol_i2c_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/vol_i2c_rx.sv
module vol_i2c_rx
    import vol_i2c_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter logic [7:0]  DEV_ADDR    = 8'h88,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_n,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    logic [1:0] line_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    rx_state_t  state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic       byte_done;
    logic       shifting;

    vol_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (line_s)
    );

    vol_i2c_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_done = scl_fall && (bit_cnt == LAST_BIT);
    assign shifting  = (state == ST_ADDR) || (state == ST_DATA);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done)
                                 nxt = (shreg[DATA_W-1 -: 8] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                ST_IGNORE:   nxt = ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start_det || stop_det || byte_done) begin
            bit_cnt <= '0;
        end else if (scl_rise && shifting) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[DATA_W-2:0], line_s[0]};
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_n <= 1'b1;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
        end else begin
            sda_pull_n <= !((nxt == ST_ADDR_ACK) || (nxt == ST_DATA_ACK));
            rx_valid   <= (state == ST_DATA) && (nxt == ST_DATA_ACK);
            if ((state == ST_DATA) && (nxt == ST_DATA_ACK))
                rx_data <= shreg;
        end
    end

    // assertions
    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r2_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && !scl_fall && !start_det && !stop_det) |=> !sda_pull_n);

    a_r6_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA_ACK && scl_fall && !start_det && !stop_det) |=> (sda_pull_n && state == ST_DATA));

    a_r3_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (sda_pull_n && !rx_valid));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sda_pull_n && !rx_valid));

    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == '0));

    always_comb begin
        if (rst_n) a_r4_count_range: assert (bit_cnt <= LAST_BIT);
    end
endmodule

// File: tb/vol_i2c_rx_tb.sv
module vol_i2c_rx_tb;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_n, rx_valid;
    logic [7:0] rx_data;
    wire  sda_line = sda_m & sda_pull_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] rx_log [16];
    int rx_cnt = 0;
    bit wide_pulse = 1'b0;
    logic prev_valid = 1'b0;

    always #10 clk = ~clk;

    vol_i2c_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_pull_n (sda_pull_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data)
    );

    always @(negedge clk) begin
        if (rx_valid && prev_valid) wide_pulse = 1'b1;
        if (rx_valid && rx_cnt < 16) begin
            rx_log[rx_cnt] = rx_data;
            rx_cnt++;
        end
        prev_valid = rx_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input bit b);
        sda_m = b;    qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    // sends a byte and returns whether the acknowledge was low across the whole high phase;
    // also reports whether SDA was released a quarter period after the ack clock fell
    task automatic send_byte(input logic [7:0] b, output bit acked, output bit released);
        bit lo_a, lo_b;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1;
        repeat (2) @(negedge clk);
        lo_a = (sda_line == 1'b0);
        qwait();
        repeat (Q - 3) @(negedge clk);
        lo_b = (sda_line == 1'b0);
        @(negedge clk);
        scl_m = 1'b0; qwait();
        released = sda_pull_n;
        acked = lo_a && lo_b;
    endtask

    // {ack expected, address, data}
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 8'h88, 8'hA3},
        {1'b1, 8'h88, 8'h00},
        {1'b1, 8'h88, 8'hFF},
        {1'b0, 8'h89, 8'h55},
        {1'b0, 8'h08, 8'h88},
        {1'b0, 8'h98, 8'h3C}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ak, rl;
        int base;
        repeat (3) @(negedge clk);
        check(sda_pull_n == 1'b1, "R1 sda_pull_n", sda_pull_n, 1);
        check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        rst_n = 1'b1;
        qwait();

        // table-driven single-byte transfers (R2, R3, R4, R5)
        for (int v = 0; v < 6; v++) begin
            base = rx_cnt;
            bus_start();
            send_byte(VEC[v][15:8], ak, rl);
            check(ak == VEC[v][16], "R2/R3 address ack", ak, VEC[v][16]);
            send_byte(VEC[v][7:0], ak, rl);
            check(ak == VEC[v][16], "R5/R3 data ack", ak, VEC[v][16]);
            bus_stop();
            qwait();
            if (VEC[v][16]) begin
                check(rx_cnt == base + 1, "R4 byte count", rx_cnt - base, 1);
                check(rx_log[base] == VEC[v][7:0], "R4 byte value", rx_log[base], VEC[v][7:0]);
            end else begin
                check(rx_cnt == base, "R3 no byte", rx_cnt - base, 0);
            end
        end

        // R5/R6: three-byte transfer, release after each ack
        base = rx_cnt;
        bus_start();
        send_byte(8'h88, ak, rl);
        check(rl == 1'b1, "R6 release after address ack", rl, 1);
        send_byte(8'hD5, ak, rl);
        check(ak && rl, "R5/R6 byte0 ack and release", {ak, rl}, 3);
        send_byte(8'h0A, ak, rl);
        check(ak && rl, "R5/R6 byte1 ack and release", {ak, rl}, 3);
        send_byte(8'hE3, ak, rl);
        check(ak && rl, "R5/R6 byte2 ack and release", {ak, rl}, 3);
        bus_stop();
        qwait();
        check(rx_cnt == base + 3, "R5 multi byte count", rx_cnt - base, 3);
        check(rx_log[base] == 8'hD5 && rx_log[base+1] == 8'h0A && rx_log[base+2] == 8'hE3,
              "R4 multi byte order", rx_log[base+2], 8'hE3);

        // R8: repeated start mid-byte
        base = rx_cnt;
        bus_start();
        send_byte(8'h88, ak, rl);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(8'h88, ak, rl);
        check(ak, "R8 address after restart", ak, 1);
        send_byte(8'h5A, ak, rl);
        bus_stop();
        qwait();
        check(rx_cnt == base + 1, "R8 partial byte dropped", rx_cnt - base, 1);
        check(rx_log[base] == 8'h5A, "R8 byte after restart", rx_log[base], 8'h5A);

        // R7: clocks after STOP without START
        base = rx_cnt;
        send_byte(8'h88, ak, rl);
        check(!ak, "R7 no ack after stop", ak, 0);
        send_byte(8'h88, ak, rl);
        check(!ak && rx_cnt == base, "R7 no byte after stop", rx_cnt - base, 0);
        bus_stop();
        qwait();

        // R3: after mismatch, recovery on next START
        base = rx_cnt;
        bus_start();
        send_byte(8'h8C, ak, rl);
        send_byte(8'h88, ak, rl);
        check(!ak, "R3 ignored 0x88 data", ak, 0);
        bus_start();
        send_byte(8'h88, ak, rl);
        check(ak, "R3 recovered at START", ak, 1);
        send_byte(8'h77, ak, rl);
        bus_stop();
        qwait();
        check(rx_cnt == base + 1 && rx_log[base] == 8'h77, "R3 byte after recovery", rx_log[base], 8'h77);

        check(!wide_pulse, "R4 strobe width", wide_pulse, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule